// File: doc/BRIEF.md
# Software-Refilled Address Translation Buffer

This block is a small, fully associative translation buffer that turns a virtual page number into a physical page number within a single cycle. A processor with split instruction and data paths uses two copies of it, one beside instruction fetch and one beside data access. The lookup is purely combinational, so it can run in the same cycle as the cache index read, and the physical page is ready for the cache tag compare.

There is no hardware page walker. When a lookup request finds no valid entry, the block raises a miss. Trap code handles the miss and loads a replacement entry through a write port fed from the system coprocessor's registers. That port carries a slot index, the virtual page, the physical page and a valid flag. A separate strobe drops every entry at once, for example on an address-space switch.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is invalid, so any lookup request reports a miss and no hit.
- R2: When `lk_req_i` is high and a valid entry holds `lk_vpn_i`, `lk_hit_o` is 1 in that same cycle and `lk_ppn_o` carries that entry's physical page.
- R3: When `lk_req_i` is high and no valid entry holds `lk_vpn_i`, `lk_miss_o` is 1 and `lk_hit_o` is 0. Hit and miss are never both 1. With `lk_req_i` low, both are 0.
- R4: A coprocessor write (`cp_wr_i` = 1) replaces the whole slot named by `cp_idx_i`. The new contents are seen by lookups from the cycle after the write edge, not in the cycle the write is presented. The slot's previous page then no longer matches.
- R5: A write with `cp_vld_i` = 0 leaves its slot invalid, so that slot no longer produces a hit.
- R6: When several valid entries hold the same virtual page, the physical page of the lowest-numbered of those slots is returned.
- R7: A one-cycle pulse on `flush_i` makes every entry invalid. From the next cycle on, every lookup misses until entries are written again.
- R8: When `flush_i` and `cp_wr_i` are both high in the same cycle, the flush wins and the write is discarded.
- R9: Whenever `lk_hit_o` is 0, `lk_ppn_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req_i | input | 1 | Lookup request qualifier |
| lk_vpn_i | input | VPN_W | Virtual page number to translate |
| lk_hit_o | output | 1 | Translation found (same cycle) |
| lk_miss_o | output | 1 | Requested translation absent; fault to software |
| lk_ppn_o | output | PPN_W | Translated physical page number, zero without a hit |
| cp_wr_i | input | 1 | Coprocessor entry write strobe |
| cp_idx_i | input | IDX_W | Slot selected for the write |
| cp_vpn_i | input | VPN_W | Virtual page written into the slot |
| cp_ppn_i | input | PPN_W | Physical page written into the slot |
| cp_vld_i | input | 1 | Valid flag written into the slot |
| flush_i | input | 1 | Invalidate every entry |

## Verification
A slot holding a wrong valid flag, page or ordering shows up at the lookup port in the first cycle that its virtual page is presented. The fault can be a hit that should be a miss, or the wrong physical page when two slots hold the same page. Write timing is exposed by presenting a page in the same cycle it is written and again one cycle later. The flush cases are exposed by looking up pages that were programmed before the flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [1:0] {
      SLOT_HOLD  = 2'd0,
      SLOT_LOAD  = 2'd1,
      SLOT_CLEAR = 2'd2
   } slot_op_e;

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
   import tlb_pkg::*;
#(
   parameter int VPN_W = 20,
   parameter int PPN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  slot_op_e         op_i,
   input  logic [VPN_W-1:0] new_vpn_i,
   input  logic [PPN_W-1:0] new_ppn_i,
   input  logic             new_vld_i,
   input  logic [VPN_W-1:0] probe_vpn_i,
   output logic             match_o,
   output logic [PPN_W-1:0] ppn_o
);

   logic             vld_q;
   logic [VPN_W-1:0] vpn_q;
   logic [PPN_W-1:0] ppn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         vpn_q <= '0;
         ppn_q <= '0;
      end else begin
         unique case (op_i)
            SLOT_LOAD: begin
               vld_q <= new_vld_i;
               vpn_q <= new_vpn_i;
               ppn_q <= new_ppn_i;
            end
            SLOT_CLEAR: vld_q <= 1'b0;
            default:    ;
         endcase
      end
   end

   assign match_o = vld_q && (vpn_q == probe_vpn_i);
   assign ppn_o   = ppn_q;

endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
   parameter int ENTRIES = 8,
   parameter int PPN_W   = 20
) (
   input  logic [ENTRIES-1:0]            match_i,
   input  logic [ENTRIES-1:0][PPN_W-1:0] ppn_i,
   output logic                          any_o,
   output logic [PPN_W-1:0]              ppn_o
);

   generate
      if (ENTRIES == 1) begin : g_single
         assign any_o = match_i[0];
         assign ppn_o = match_i[0] ? ppn_i[0] : '0;
      end else begin : g_multi
         always_comb begin
            any_o = 1'b0;
            ppn_o = '0;
            for (int i = ENTRIES - 1; i >= 0; i--) begin
               if (match_i[i]) begin
                  any_o = 1'b1;
                  ppn_o = ppn_i[i];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
   import tlb_pkg::*;
#(
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int ENTRIES = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_req_i,
   input  logic [VPN_W-1:0] lk_vpn_i,
   output logic             lk_hit_o,
   output logic             lk_miss_o,
   output logic [PPN_W-1:0] lk_ppn_o,
   input  logic             cp_wr_i,
   input  logic [IDX_W-1:0] cp_idx_i,
   input  logic [VPN_W-1:0] cp_vpn_i,
   input  logic [PPN_W-1:0] cp_ppn_i,
   input  logic             cp_vld_i,
   input  logic             flush_i
);

   if (VPN_W < 1) begin : g_bad_vpn
      $error("xlat_buffer: VPN_W must be at least 1");
   end
   if (PPN_W < 1) begin : g_bad_ppn
      $error("xlat_buffer: PPN_W must be at least 1");
   end
   if (ENTRIES < 1 || ENTRIES > 64) begin : g_bad_entries
      $error("xlat_buffer: ENTRIES must be within 1..64");
   end

   logic [ENTRIES-1:0]            slot_match;
   logic [ENTRIES-1:0][PPN_W-1:0] slot_ppn;
   slot_op_e                      slot_op [ENTRIES];
   logic                          any_match;
   logic [PPN_W-1:0]              sel_ppn;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      always_comb begin
         if (flush_i)
            slot_op[g] = SLOT_CLEAR;
         else if (cp_wr_i && (cp_idx_i == IDX_W'(g)))
            slot_op[g] = SLOT_LOAD;
         else
            slot_op[g] = SLOT_HOLD;
      end

      tlb_slot #(
         .VPN_W (VPN_W),
         .PPN_W (PPN_W)
      ) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .op_i        (slot_op[g]),
         .new_vpn_i   (cp_vpn_i),
         .new_ppn_i   (cp_ppn_i),
         .new_vld_i   (cp_vld_i),
         .probe_vpn_i (lk_vpn_i),
         .match_o     (slot_match[g]),
         .ppn_o       (slot_ppn[g])
      );
   end

   tlb_prio_sel #(
      .ENTRIES (ENTRIES),
      .PPN_W   (PPN_W)
   ) u_sel (
      .match_i (slot_match),
      .ppn_i   (slot_ppn),
      .any_o   (any_match),
      .ppn_o   (sel_ppn)
   );

   assign lk_hit_o  = lk_req_i && any_match;
   assign lk_miss_o = lk_req_i && !any_match;
   assign lk_ppn_o  = lk_hit_o ? sel_ppn : '0;

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
   parameter int VPN_W = 20,
   parameter int PPN_W = 20,
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_req_i,
   input logic [VPN_W-1:0] lk_vpn_i,
   input logic             lk_hit_o,
   input logic             lk_miss_o,
   input logic [PPN_W-1:0] lk_ppn_o,
   input logic             cp_wr_i,
   input logic [IDX_W-1:0] cp_idx_i,
   input logic [VPN_W-1:0] cp_vpn_i,
   input logic             cp_vld_i,
   input logic             flush_i
);

   assert_first_cycle_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !lk_hit_o);

   assert_hit_miss_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit_o && lk_miss_o));

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req_i |-> (!lk_hit_o && !lk_miss_o));

   assert_request_answered_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req_i |-> (lk_hit_o || lk_miss_o));

   assert_written_page_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cp_wr_i && cp_vld_i && !flush_i) && lk_req_i && (lk_vpn_i == $past(cp_vpn_i)))
         |-> lk_hit_o);

   assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flush_i) |-> !lk_hit_o);

   assert_ppn_zero_on_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit_o |-> (lk_ppn_o == '0));

   // cp_idx_i is part of the bound port set; it is never X while writing
   assert_write_index_known_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cp_wr_i |-> !$isunknown(cp_idx_i));

endmodule

bind xlat_buffer tlb_checker #(
   .VPN_W (VPN_W),
   .PPN_W (PPN_W),
   .IDX_W (IDX_W)
) u_tlb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_req_i  (lk_req_i),
   .lk_vpn_i  (lk_vpn_i),
   .lk_hit_o  (lk_hit_o),
   .lk_miss_o (lk_miss_o),
   .lk_ppn_o  (lk_ppn_o),
   .cp_wr_i   (cp_wr_i),
   .cp_idx_i  (cp_idx_i),
   .cp_vpn_i  (cp_vpn_i),
   .cp_vld_i  (cp_vld_i),
   .flush_i   (flush_i)
);

// File: tb/test_xlat_buffer.sv
module test_xlat_buffer;

   localparam int CLK_PERIOD = 10;
   localparam int VPN_W   = 20;
   localparam int PPN_W   = 20;
   localparam int ENTRIES = 8;
   localparam int IDX_W   = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lk_req_i = 1'b0;
   logic [VPN_W-1:0] lk_vpn_i = '0;
   logic             lk_hit_o;
   logic             lk_miss_o;
   logic [PPN_W-1:0] lk_ppn_o;
   logic             cp_wr_i = 1'b0;
   logic [IDX_W-1:0] cp_idx_i = '0;
   logic [VPN_W-1:0] cp_vpn_i = '0;
   logic [PPN_W-1:0] cp_ppn_i = '0;
   logic             cp_vld_i = 1'b0;
   logic             flush_i = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xlat_buffer #(
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W),
      .ENTRIES (ENTRIES)
   ) i_xlat_buffer (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_req_i  (lk_req_i),
      .lk_vpn_i  (lk_vpn_i),
      .lk_hit_o  (lk_hit_o),
      .lk_miss_o (lk_miss_o),
      .lk_ppn_o  (lk_ppn_o),
      .cp_wr_i   (cp_wr_i),
      .cp_idx_i  (cp_idx_i),
      .cp_vpn_i  (cp_vpn_i),
      .cp_ppn_i  (cp_ppn_i),
      .cp_vld_i  (cp_vld_i),
      .flush_i   (flush_i)
   );

   // {vpn[19:0], hit, ppn[19:0]}
   localparam int NVEC = 7;
   localparam logic [40:0] VEC [NVEC] = '{
      {20'h00010, 1'b1, 20'hA0010},   // R2
      {20'h00020, 1'b1, 20'hA0020},   // R6: slot 1 beats slot 5
      {20'h12345, 1'b1, 20'h54321},   // R2
      {20'hFFFFF, 1'b1, 20'h00001},   // R2
      {20'h00030, 1'b0, 20'h00000},   // R5: written invalid
      {20'h00000, 1'b0, 20'h00000},   // R3: matches reset contents of empty slots
      {20'h12344, 1'b0, 20'h00000}    // R3
   };

   task automatic check_lookup(input logic [VPN_W-1:0] vpn, input bit exp_hit,
                               input logic [PPN_W-1:0] exp_ppn, input string req);
      lk_req_i = 1'b1;
      lk_vpn_i = vpn;
      #1;
      n_checks++;
      if (lk_hit_o !== exp_hit || lk_miss_o !== !exp_hit || lk_ppn_o !== exp_ppn) begin
         n_fail++;
         $display("FAIL %s vpn=%h: hit=%b miss=%b ppn=%h expected hit=%b miss=%b ppn=%h",
                  req, vpn, lk_hit_o, lk_miss_o, lk_ppn_o, exp_hit, !exp_hit, exp_ppn);
      end
   endtask

   task automatic write_slot(input int idx, input logic [VPN_W-1:0] vpn,
                             input logic [PPN_W-1:0] ppn, input bit vld);
      @(negedge clk);
      cp_wr_i  = 1'b1;
      cp_idx_i = IDX_W'(idx);
      cp_vpn_i = vpn;
      cp_ppn_i = ppn;
      cp_vld_i = vld;
      @(negedge clk);
      cp_wr_i  = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: empty after reset
      check_lookup(20'h00000, 1'b0, 20'h0, "R1");
      check_lookup(20'h00010, 1'b0, 20'h0, "R1");

      write_slot(0, 20'h00010, 20'hA0010, 1'b1);
      write_slot(1, 20'h00020, 20'hA0020, 1'b1);
      write_slot(2, 20'h00030, 20'hCCCCC, 1'b0);
      write_slot(3, 20'h12345, 20'h54321, 1'b1);
      write_slot(5, 20'h00020, 20'hBBBBB, 1'b1);
      write_slot(7, 20'hFFFFF, 20'h00001, 1'b1);

      for (int v = 0; v < NVEC; v++) begin
         check_lookup(VEC[v][40:21], VEC[v][20], VEC[v][19:0], "R2/R3/R5/R6 table");
      end

      // R5 + R6: invalidate slot 1, slot 5 now supplies the page
      write_slot(1, 20'h00020, 20'hA0020, 1'b0);
      check_lookup(20'h00020, 1'b1, 20'hBBBBB, "R5/R6");

      // R4: not visible in the write cycle, visible after the edge
      @(negedge clk);
      cp_wr_i = 1'b1; cp_idx_i = 3'd4; cp_vpn_i = 20'h00777; cp_ppn_i = 20'h07777; cp_vld_i = 1'b1;
      check_lookup(20'h00777, 1'b0, 20'h0, "R4 same cycle");
      @(negedge clk);
      cp_wr_i = 1'b0;
      check_lookup(20'h00777, 1'b1, 20'h07777, "R4 next cycle");

      // R4: overwriting a slot retires its old page
      write_slot(4, 20'h00888, 20'h08888, 1'b1);
      check_lookup(20'h00777, 1'b0, 20'h0, "R4 old page");
      check_lookup(20'h00888, 1'b1, 20'h08888, "R4 new page");

      // R3 + R9: no request, nothing reported, page zero
      lk_req_i = 1'b0;
      lk_vpn_i = 20'h00888;
      #1;
      n_checks++;
      if (lk_hit_o !== 1'b0 || lk_miss_o !== 1'b0 || lk_ppn_o !== '0) begin
         n_fail++;
         $display("FAIL R3/R9 idle: hit=%b miss=%b ppn=%h expected hit=0 miss=0 ppn=00000",
                  lk_hit_o, lk_miss_o, lk_ppn_o);
      end

      // R7 + R8: flush with a concurrent write
      @(negedge clk);
      flush_i = 1'b1;
      cp_wr_i = 1'b1; cp_idx_i = 3'd6; cp_vpn_i = 20'h00999; cp_ppn_i = 20'h09999; cp_vld_i = 1'b1;
      @(negedge clk);
      flush_i = 1'b0;
      cp_wr_i = 1'b0;
      check_lookup(20'h00999, 1'b0, 20'h0, "R8");
      check_lookup(20'h00010, 1'b0, 20'h0, "R7");
      check_lookup(20'h00020, 1'b0, 20'h0, "R7");
      check_lookup(20'hFFFFF, 1'b0, 20'h0, "R7");
      check_lookup(20'h00888, 1'b0, 20'h0, "R7");

      // R7: buffer usable again after flush
      write_slot(6, 20'h00999, 20'h09999, 1'b1);
      check_lookup(20'h00999, 1'b1, 20'h09999, "R7 refill");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule